// File: doc/BRIEF.md
# Key Matrix Scanner with Byte Packing

This block reads a six-by-four key matrix once per display frame. While the frame's key-scan window is open it walks a single active drive across six scan lines, one after another. Each line is held for an equal number of clock cycles, and the four return inputs are sampled on the last cycle of that line's share of the window. The samples collect in a working copy. The copy is moved into the readable key store only at the frame-end pulse, and only if all six lines were sampled during that frame.

The four general-purpose switch inputs are captured at the same frame-end pulse. The key store is presented as three bytes and the switch port as one byte, with its upper nibble tied to zero, so that a separate serial read-back engine can shift them out. Any frame whose scan window was missing or cut short leaves the key store unchanged.

Top module: `key_matrix_scanner`

## Requirements
- R1: While `scan_slot_i` is high, `scan_drv_o` has exactly one bit set until all lines have been sampled. The set bit walks from bit 0 (line 1) to bit 5 (line 6), and each line is held for SUB_CYCLES (default 4) clock cycles counted from the rising of the window. After the sixth line, and whenever `scan_slot_i` is low, `scan_drv_o` is all zero.
- R2: The four return inputs are sampled on the last cycle of each line's sub-slot. They are stored as the nibble of that line, with `keys_i[0]` (return 1) in the nibble's bit 0.
- R3: Key byte 0 is `key_bytes_o[7:0]`, byte 1 is `[15:8]` and byte 2 is `[23:16]`. Byte 0 holds line 1 in bits 0–3 and line 2 in bits 4–7. Byte 1 holds lines 3 and 4, and byte 2 holds lines 5 and 6, with the lower line always in the lower nibble.
- R4: `sw_byte_o` changes only on the cycle after a clock edge at which `frame_end_i` is high. At that edge it takes the value of `sw_i`.
- R5: `sw_i[0]` appears in bit 0 of `sw_byte_o`, in order up to `sw_i[3]` in bit 3. Bits 7–4 of `sw_byte_o` are always 0.
- R6: `key_bytes_o` changes only at a frame-end edge. A scan that has run without a frame-end pulse does not show on the outputs.
- R7: At a frame-end edge the key store is updated only if all six lines were sampled since the previous frame end. If the window was absent or cut short, the key store keeps its previous value.
- R8: After reset, `scan_drv_o`, `key_bytes_o` and `sw_byte_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_slot_i | input | 1 | High during the frame's key-scan window |
| frame_end_i | input | 1 | One-cycle pulse at the end of a display frame |
| keys_i | input | 4 | Return inputs from the key matrix |
| sw_i | input | 4 | General-purpose switch inputs |
| scan_drv_o | output | 6 | One-hot scan-line drive, active high |
| key_bytes_o | output | 24 | Key store as three bytes, byte 0 in bits 7:0 |
| sw_byte_o | output | 8 | Latched switch byte, upper nibble zero |

## Verification
On every cycle the assertions check several properties: the drive has at most one bit set, the drive is silent outside the scan window, the switch byte's upper nibble is zero, and neither the key bytes nor the switch byte move without a frame-end pulse. Other behaviours can only be shown by the bench's scenarios, because they depend on what the matrix holds. These are: that each key lands in the right nibble of the right byte, which line is driven at a given point in the window, that an aborted or missing window leaves the store intact, and that a complete scan becomes visible exactly at frame end. The bench models the matrix as switches between the drive lines and the return inputs.

// File: rtl/kms_pkg.sv
package kms_pkg;
    localparam int KMS_LINES      = 6;
    localparam int KMS_RETURNS    = 4;
    localparam int KMS_SUB_CYCLES = 4;
    localparam int KMS_SW_BITS    = 4;
endpackage

// File: rtl/kms_scan_seq.sv
module kms_scan_seq #(
    parameter int LINES       = 6,
    parameter int SUB_CYCLES  = 4,
    localparam int LINE_W     = $clog2(LINES + 1),
    localparam int CNT_W      = (SUB_CYCLES > 1) ? $clog2(SUB_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_i,
    input  logic              frame_end_i,
    output logic [LINES-1:0]  drive_o,
    output logic [LINE_W-1:0] line_o,
    output logic              sample_o,
    output logic              commit_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [LINE_W-1:0] line;
        logic              full;
    } seq_t;

    seq_t st_d, st_q;
    logic smp_d;

    always_comb begin
        st_d  = st_q;
        smp_d = 1'b0;
        if (frame_end_i) begin
            st_d.cnt  = '0;
            st_d.line = '0;
            st_d.full = 1'b0;
        end else if (!slot_i) begin
            st_d.cnt  = '0;
            st_d.line = '0;
        end else if (st_q.line < LINE_W'(LINES)) begin
            if (st_q.cnt == CNT_W'(SUB_CYCLES - 1)) begin
                smp_d     = 1'b1;
                st_d.cnt  = '0;
                st_d.line = st_q.line + 1'b1;
                if (st_q.line == LINE_W'(LINES - 1)) begin
                    st_d.full = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar l = 0; l < LINES; l++) begin : g_drv
        assign drive_o[l] = slot_i && (st_q.line == LINE_W'(l));
    end

    assign line_o   = st_q.line;
    assign sample_o = smp_d;
    assign commit_o = frame_end_i && st_q.full;
endmodule

// File: rtl/kms_key_capture.sv
module kms_key_capture #(
    parameter int LINES    = 6,
    parameter int RETURNS  = 4,
    localparam int W       = LINES * RETURNS,
    localparam int LINE_W  = $clog2(LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              commit_i,
    input  logic [RETURNS-1:0] keys_i,
    output logic [W-1:0]      store_o
);
    typedef struct packed {
        logic [W-1:0] shadow;
        logic [W-1:0] store;
    } cap_t;

    cap_t cp_d, cp_q;

    always_comb begin
        cp_d = cp_q;
        for (int l = 0; l < LINES; l++) begin
            if (sample_i && (line_i == LINE_W'(l))) begin
                cp_d.shadow[l*RETURNS +: RETURNS] = keys_i;
            end
        end
        if (commit_i) begin
            cp_d.store = cp_q.shadow;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cp_q <= '0;
        end else begin
            cp_q <= cp_d;
        end
    end

    assign store_o = cp_q.store;
endmodule

// File: rtl/kms_sw_latch.sv
module kms_sw_latch #(
    parameter int SW_BITS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_end_i,
    input  logic [SW_BITS-1:0] sw_i,
    output logic [7:0]         sw_byte_o
);
    logic [SW_BITS-1:0] sw_d, sw_q;

    always_comb begin
        sw_d = sw_q;
        if (frame_end_i) begin
            sw_d = sw_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= '0;
        end else begin
            sw_q <= sw_d;
        end
    end

    assign sw_byte_o = 8'(sw_q);
endmodule

// File: rtl/key_matrix_scanner.sv
module key_matrix_scanner
    import kms_pkg::*;
#(
    parameter int LINES      = KMS_LINES,
    parameter int RETURNS    = KMS_RETURNS,
    parameter int SUB_CYCLES = KMS_SUB_CYCLES,
    parameter int SW_BITS    = KMS_SW_BITS,
    localparam int W         = LINES * RETURNS,
    localparam int LINE_W    = $clog2(LINES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_slot_i,
    input  logic               frame_end_i,
    input  logic [RETURNS-1:0] keys_i,
    input  logic [SW_BITS-1:0] sw_i,
    output logic [LINES-1:0]   scan_drv_o,
    output logic [W-1:0]       key_bytes_o,
    output logic [7:0]         sw_byte_o
);
    logic [LINE_W-1:0] line_w;
    logic              sample_w;
    logic              commit_w;

    kms_scan_seq #(.LINES(LINES), .SUB_CYCLES(SUB_CYCLES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_i     (scan_slot_i),
        .frame_end_i(frame_end_i),
        .drive_o    (scan_drv_o),
        .line_o     (line_w),
        .sample_o   (sample_w),
        .commit_o   (commit_w)
    );

    kms_key_capture #(.LINES(LINES), .RETURNS(RETURNS)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample_i(sample_w),
        .line_i  (line_w),
        .commit_i(commit_w),
        .keys_i  (keys_i),
        .store_o (key_bytes_o)
    );

    kms_sw_latch #(.SW_BITS(SW_BITS)) u_sw (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_end_i(frame_end_i),
        .sw_i       (sw_i),
        .sw_byte_o  (sw_byte_o)
    );
endmodule

// File: rtl/key_matrix_scanner_chk.sv
module key_matrix_scanner_chk
    import kms_pkg::*;
(
    input logic                                clk,
    input logic                                rst_n,
    input logic                                scan_slot_i,
    input logic                                frame_end_i,
    input logic [KMS_LINES-1:0]                scan_drv_o,
    input logic [KMS_LINES*KMS_RETURNS-1:0]    key_bytes_o,
    input logic [7:0]                          sw_byte_o
);
    // R1: never more than one scan line driven
    a_r1_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(scan_drv_o));

    // R1: drive silent outside the scan window
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_slot_i |-> (scan_drv_o == '0));

    // R4: switch byte moves only after a frame-end edge
    a_r4_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end_i |=> $stable(sw_byte_o));

    // R5: upper nibble of switch byte is zero
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sw_byte_o[7:4] == 4'h0);

    // R6: key bytes move only after a frame-end edge
    a_r6_keys_atomic: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end_i |=> $stable(key_bytes_o));
endmodule

bind key_matrix_scanner key_matrix_scanner_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_slot_i(scan_slot_i),
    .frame_end_i(frame_end_i),
    .scan_drv_o (scan_drv_o),
    .key_bytes_o(key_bytes_o),
    .sw_byte_o  (sw_byte_o)
);

// File: tb/key_matrix_scanner_bench.sv
`timescale 1ns/1ps
module key_matrix_scanner_bench;
    localparam int SUB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_slot = 1'b0;
    logic        frame_end = 1'b0;
    logic [3:0]  keys;
    logic [3:0]  sw = 4'h0;
    logic [5:0]  drv;
    logic [23:0] kbytes;
    logic [7:0]  swb;
    logic [23:0] mat = 24'h0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    key_matrix_scanner u_key_matrix_scanner (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_slot_i(scan_slot),
        .frame_end_i(frame_end),
        .keys_i     (keys),
        .sw_i       (sw),
        .scan_drv_o (drv),
        .key_bytes_o(kbytes),
        .sw_byte_o  (swb)
    );

    // matrix model: pressed keys connect a driven line to the return inputs
    always_comb begin
        keys = 4'h0;
        for (int l = 0; l < 6; l++) begin
            if (drv[l]) keys = keys | mat[l*4 +: 4];
        end
    end

    typedef struct packed {
        logic [23:0] m;
        logic [3:0]  s;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [7:0]  b2;
        logic [7:0]  sb;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{24'h000001, 4'h5, 8'h01, 8'h00, 8'h00, 8'h05},
        '{24'h800000, 4'hF, 8'h00, 8'h00, 8'h80, 8'h0F},
        '{24'h0000F0, 4'h0, 8'hF0, 8'h00, 8'h00, 8'h00},
        '{24'h3C5A96, 4'hA, 8'h96, 8'h5A, 8'h3C, 8'h0A},
        '{24'hFFFFFF, 4'h3, 8'hFF, 8'hFF, 8'hFF, 8'h03},
        '{24'h000000, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic scan(input int cycles);
        scan_slot = 1'b1;
        repeat (cycles) @(negedge clk);
        scan_slot = 1'b0;
        @(negedge clk);
    endtask

    task automatic fend();
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 drive after reset", 32'(drv), 32'h0);
        check("R8 keys after reset", 32'(kbytes), 32'h0);
        check("R8 switch after reset", 32'(swb), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: drive walk inside one window
        mat = 24'h0;
        check("R1 idle drive", 32'(drv), 32'h0);
        scan_slot = 1'b1;
        #1;
        check("R1 first line at window start", 32'(drv), 32'h01);
        repeat (2*SUB + 1) @(negedge clk);
        check("R1 third line mid window", 32'(drv), 32'h04);
        repeat (4*SUB - 1) @(negedge clk);
        check("R1 silent after six lines", 32'(drv), 32'h0);
        scan_slot = 1'b0;
        @(negedge clk);
        fend();

        // table walk: R2 R3 R5
        for (int i = 0; i < 6; i++) begin
            mat = VECS[i].m;
            sw  = VECS[i].s;
            scan(6*SUB + 2);
            fend();
            check("R3 R2 byte0", 32'(kbytes[7:0]),   32'(VECS[i].b0));
            check("R3 byte1",    32'(kbytes[15:8]),  32'(VECS[i].b1));
            check("R3 byte2",    32'(kbytes[23:16]), 32'(VECS[i].b2));
            check("R5 switch byte", 32'(swb), 32'(VECS[i].sb));
        end

        // base state
        mat = 24'h123456; sw = 4'h1;
        scan(6*SUB + 2);
        fend();
        check("R3 base keys", 32'(kbytes), 32'h123456);

        // R6: scan without frame end stays hidden
        mat = 24'hABCDEF;
        scan(6*SUB + 2);
        check("R6 no commit before frame end", 32'(kbytes), 32'h123456);

        // R4: switch change without frame end ignored
        sw = 4'hE;
        repeat (5) @(negedge clk);
        check("R4 switch held", 32'(swb), 32'h01);
        fend();
        check("R6 commit at frame end", 32'(kbytes), 32'hABCDEF);
        check("R4 switch latched", 32'(swb), 32'h0E);

        // R7: aborted window
        mat = 24'h777777;
        scan(2*SUB);
        fend();
        check("R7 aborted scan holds", 32'(kbytes), 32'hABCDEF);

        // R7: no window at all, switches still latch
        sw = 4'h9;
        fend();
        check("R7 absent scan holds", 32'(kbytes), 32'hABCDEF);
        check("R4 switch latched without scan", 32'(swb), 32'h09);

        // R7: complete scan afterwards commits
        scan(6*SUB + 2);
        fend();
        check("R7 full scan after abort", 32'(kbytes), 32'h777777);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule